// File: doc/BRIEF.md
# Frame-Referenced RC Oscillator Trim Servo

This block tunes an on-chip 8 MHz RC oscillator against the 1 ms start-of-frame pulse of a USB link. It runs on the oscillator clock itself. It counts oscillator cycles from one reference pulse to the next and compares that count with the nominal 8000. It then moves one of two trim words toward the nominal count. The coarse word shifts the frequency by about 40 kHz per unit and the fine word by about 20 kHz per unit. In both words a larger value gives a higher frequency. The oscillator sits outside the block and reads both words from output ports.

Software drives the block through a two-address register interface with write and read strobes. The control address holds the enable, the coarse/fine choice, the size of each adjustment and two interrupt enables. The status address holds a lock flag, set once the best setting has been reached, and a missing-reference flag. Either flag can drive a single interrupt line. The reference pulse arrives asynchronously and is synchronized inside the block.

Top module: `osc_trim_ctrl`

## Requirements
- R1: After reset the coarse word equals COARSE_INIT (128), the fine word equals FINE_INIT (32), both flags and irq are 0, and the control address reads 0x10 (step 1, everything else 0).
- R2: Address 0 holds the control fields: bit 0 enable, bit 1 fine select, bit 2 lock interrupt enable, bit 3 lost interrupt enable, bits 7:4 step. Address 1 holds bit 0 lock flag and bit 1 lost flag, with the other bits reading 0. reg_rdata is 0 whenever reg_rd is low.
- R3: sof_in passes through two synchronizing flops, and each rising edge becomes one reference event. Events count only while enable is 1. The first event after enable, or after a lost condition, only starts timing.
- R4: At each later event the period is the number of clock cycles since the previous event, and the error is that period minus NOMINAL. A positive error lowers the selected word by step. A negative error raises it by step.
- R5: With fine select 0 only the coarse word changes. With fine select 1 only the fine word changes.
- R6: Trim words saturate at 0 and at their all-ones value and never wrap.
- R7: A zero error sets the lock flag and keeps the word. A reversal of adjustment direction also sets the lock flag, and it restores the previous word only if that word's error magnitude was strictly smaller. While locked no word changes.
- R8: If LOST_LIMIT = 3*NOMINAL/2 cycles pass with no event while enabled, the lost flag is set. While it is set no word changes, and the next event only restarts timing.
- R9: When enable reads 0 both flags are 0 one cycle later. Writing a 0 to a status bit clears that flag, and writing a 1 to it has no effect.
- R10: irq is 1 exactly when (lock flag and lock interrupt enable) or (lost flag and lost interrupt enable).
- R11: Once software clears the lock flag with enable still 1, the search starts again from the current word with no memory of earlier errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock being trimmed |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof_in | input | 1 | Asynchronous start-of-frame reference pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | Register address (0 control, 1 status) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| coarse_trim | output | 8 | Coarse trim word to the oscillator |
| fine_trim | output | 6 | Fine trim word to the oscillator |
| irq | output | 1 | Interrupt request |

## Verification
A wrong count or a wrong direction decision shows up on a trim port one clock after the synchronized reference event that triggered it. The bench's oscillator model then feeds that error into the next period, so the final locked word drifts away from its predicted value. A bad lock decision or bad history shows as a lock flag and irq that rise one interval early or late, or as a word that is not restored. A lost-reference counter that is off by one moves the lost flag by a single cycle. The bench's per-clock reference model catches all of these on the first cycle where they differ.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;

  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } trim_dir_e;

  // Signed distance of a measured period from its nominal value.
  function automatic int period_error(input int period, input int nominal);
    return period - nominal;
  endfunction

  // Too many cycles means the oscillator runs fast, so the word goes down.
  function automatic trim_dir_e error_dir(input int err);
    if (err > 0) return DIR_DOWN;
    if (err < 0) return DIR_UP;
    return DIR_NONE;
  endfunction

  function automatic int abs_err(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // Saturating move of a trim word in the given direction.
  function automatic int sat_move(input int word, input int step,
                                  input trim_dir_e dir, input int max_word);
    int r;
    r = word;
    if (dir == DIR_UP)   r = word + step;
    if (dir == DIR_DOWN) r = word - step;
    if (r < 0) r = 0;
    if (r > max_word) r = max_word;
    return r;
  endfunction

endpackage

// File: rtl/ot_sof_sync.sv
module ot_sof_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic sof_async,
  output logic sof_event
);
  // chain_q[0..SYNC_STAGES-1] synchronize, chain_q[SYNC_STAGES] holds the previous level
  logic [SYNC_STAGES:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= sof_async;
  end

  for (genvar g = 1; g <= SYNC_STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[g] <= 1'b0;
      else        chain_q[g] <= chain_q[g-1];
    end
  end

  logic sync_level, prev_level;
  assign sync_level = chain_q[SYNC_STAGES-1];
  assign prev_level = chain_q[SYNC_STAGES];
  assign sof_event  = enable & sync_level & ~prev_level;

  a_r3_single_cycle_event: assert property (@(posedge clk) disable iff (!rst_n)
    sof_event |=> !sof_event);

endmodule

// File: rtl/ot_period_meter.sv
module ot_period_meter #(
  parameter int NOMINAL    = 8000,
  parameter int LOST_LIMIT = 12000,
  parameter int CNT_W      = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cal_en,
  input  logic             sof_event,
  input  logic             lost_flag,
  output logic             meas_valid,
  output logic [CNT_W:0]   period,
  output logic             lost_event
);
  localparam logic [CNT_W-1:0] LIMIT_M1 = CNT_W'(LOST_LIMIT - 1);
  localparam logic [CNT_W-1:0] LIMIT_V  = CNT_W'(LOST_LIMIT);

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             window_full;

  assign window_full = (cnt_q == LIMIT_M1);
  assign lost_event  = cal_en & ~sof_event & window_full;
  assign meas_valid  = cal_en & sof_event & armed_q & ~lost_flag;
  assign period      = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (!cal_en) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (sof_event) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else begin
      if (cnt_q < LIMIT_V) cnt_q <= cnt_q + 1'b1;
      if (lost_event) armed_q <= 1'b0;
    end
  end

  a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT_V);
  a_r8_lost_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    lost_event |=> !armed_q);
  a_r3_event_restarts_count: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_en && sof_event) |=> (cnt_q == '0));
  a_r3_no_event_while_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_en |=> (cnt_q == '0) && !armed_q);

endmodule

// File: rtl/ot_trim_servo.sv
module ot_trim_servo
  import osc_trim_pkg::*;
#(
  parameter int NOMINAL     = 8000,
  parameter int COARSE_W    = 8,
  parameter int FINE_W      = 6,
  parameter int COARSE_INIT = 128,
  parameter int FINE_INIT   = 32,
  parameter int STEP_W      = 4,
  parameter int PER_W       = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cal_en,
  input  logic                fine_sel,
  input  logic [STEP_W-1:0]   step,
  input  logic                hold,
  input  logic                lost_flag,
  input  logic                meas_valid,
  input  logic [PER_W-1:0]    period,
  output logic [COARSE_W-1:0] coarse_word,
  output logic [FINE_W-1:0]   fine_word,
  output logic                lock_event
);
  localparam int COARSE_MAX = (1 << COARSE_W) - 1;
  localparam int FINE_MAX   = (1 << FINE_W) - 1;

  logic [COARSE_W-1:0] coarse_q;
  logic [FINE_W-1:0]   fine_q;
  logic                have_prev_q;
  trim_dir_e           prev_dir_q;
  int                  prev_err_q;
  int                  prev_word_q;

  int        err;
  trim_dir_e dir;
  int        cur_word;
  int        max_word;
  int        next_word;
  logic      adjust;
  logic      reversal;
  logic      settle;
  logic      use_prev;

  always_comb begin
    err       = period_error(int'(period), NOMINAL);
    dir       = error_dir(err);
    cur_word  = fine_sel ? int'(fine_q) : int'(coarse_q);
    max_word  = fine_sel ? FINE_MAX : COARSE_MAX;
    adjust    = meas_valid & ~hold;
    reversal  = have_prev_q && (dir != DIR_NONE) && (dir != prev_dir_q);
    settle    = adjust && ((dir == DIR_NONE) || reversal);
    use_prev  = reversal && (abs_err(prev_err_q) < abs_err(err));
    next_word = cur_word;
    if (adjust) begin
      if (settle) next_word = use_prev ? prev_word_q : cur_word;
      else        next_word = sat_move(cur_word, int'(step), dir, max_word);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coarse_q <= COARSE_W'(COARSE_INIT);
      fine_q   <= FINE_W'(FINE_INIT);
    end else if (adjust) begin
      if (fine_sel) fine_q   <= FINE_W'(next_word);
      else          coarse_q <= COARSE_W'(next_word);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev_q <= 1'b0;
      prev_dir_q  <= DIR_NONE;
      prev_err_q  <= 0;
      prev_word_q <= 0;
    end else begin
      if (!cal_en || hold || lost_flag) have_prev_q <= 1'b0;
      else if (adjust && !settle)       have_prev_q <= 1'b1;
      if (adjust && !settle) begin
        prev_dir_q  <= dir;
        prev_err_q  <= err;
        prev_word_q <= cur_word;
      end
    end
  end

  assign coarse_word = coarse_q;
  assign fine_word   = fine_q;
  assign lock_event  = settle;

  a_r5_fine_leaves_coarse: assert property (@(posedge clk) disable iff (!rst_n)
    fine_sel |=> $stable(coarse_q));
  a_r5_coarse_leaves_fine: assert property (@(posedge clk) disable iff (!rst_n)
    !fine_sel |=> $stable(fine_q));
  a_r7_hold_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(coarse_q) && $stable(fine_q));
  a_r8_hold_when_lost: assert property (@(posedge clk) disable iff (!rst_n)
    lost_flag |=> $stable(coarse_q) && $stable(fine_q));
  a_r4_down_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adjust && !settle && dir == DIR_DOWN && !fine_sel && int'(coarse_q) >= int'(step))
    |=> int'(coarse_q) == int'($past(coarse_q)) - int'($past(step)));
  a_r6_top_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (adjust && dir == DIR_UP && !fine_sel && int'(coarse_q) == COARSE_MAX)
    |=> int'(coarse_q) == COARSE_MAX);

endmodule

// File: rtl/ot_ctrl_regs.sv
module ot_ctrl_regs #(
  parameter int STEP_W    = 4,
  parameter int STEP_INIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              lock_event,
  input  logic              lost_event,
  output logic              cal_en,
  output logic              fine_sel,
  output logic [STEP_W-1:0] step,
  output logic              ready_flag,
  output logic              lost_flag,
  output logic              irq
);
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

  logic              cal_en_q, fine_sel_q, rdy_ie_q, lost_ie_q;
  logic [STEP_W-1:0] step_q;
  logic              ready_q, lost_q;
  logic              ctrl_wr, stat_wr;

  assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);
  assign stat_wr = reg_wr && (reg_addr == ADDR_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_en_q   <= 1'b0;
      fine_sel_q <= 1'b0;
      rdy_ie_q   <= 1'b0;
      lost_ie_q  <= 1'b0;
      step_q     <= STEP_W'(STEP_INIT);
    end else if (ctrl_wr) begin
      cal_en_q   <= reg_wdata[0];
      fine_sel_q <= reg_wdata[1];
      rdy_ie_q   <= reg_wdata[2];
      lost_ie_q  <= reg_wdata[3];
      step_q     <= reg_wdata[4 +: STEP_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      lost_q  <= 1'b0;
    end else if (!cal_en_q) begin
      ready_q <= 1'b0;
      lost_q  <= 1'b0;
    end else begin
      if (lock_event) ready_q <= 1'b1;
      if (lost_event) lost_q  <= 1'b1;
      if (stat_wr && !reg_wdata[0]) ready_q <= 1'b0;
      if (stat_wr && !reg_wdata[1]) lost_q  <= 1'b0;
    end
  end

  logic [7:0] ctrl_view, stat_view;
  assign ctrl_view = {step_q, lost_ie_q, rdy_ie_q, fine_sel_q, cal_en_q};
  assign stat_view = {6'd0, lost_q, ready_q};
  assign reg_rdata = !reg_rd ? 8'd0 : ((reg_addr == ADDR_CTRL) ? ctrl_view : stat_view);

  assign cal_en     = cal_en_q;
  assign fine_sel   = fine_sel_q;
  assign step       = step_q;
  assign ready_flag = ready_q;
  assign lost_flag  = lost_q;
  assign irq        = (ready_q & rdy_ie_q) | (lost_q & lost_ie_q);

  a_r9_off_clears_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_en_q |=> !ready_q && !lost_q);
  a_r9_zero_clears_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_en_q && stat_wr && !reg_wdata[0]) |=> !ready_q);
  a_r9_zero_clears_lost: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_en_q && stat_wr && !reg_wdata[1]) |=> !lost_q);
  a_r10_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ready_q || lost_q));

endmodule

// File: rtl/osc_trim_ctrl.sv
module osc_trim_ctrl #(
  parameter int NOMINAL     = 8000,
  parameter int COARSE_W    = 8,
  parameter int FINE_W      = 6,
  parameter int COARSE_INIT = 128,
  parameter int FINE_INIT   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sof_in,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic                reg_addr,
  input  logic [7:0]          reg_wdata,
  output logic [7:0]          reg_rdata,
  output logic [COARSE_W-1:0] coarse_trim,
  output logic [FINE_W-1:0]   fine_trim,
  output logic                irq
);
  localparam int STEP_W     = 4;
  localparam int LOST_LIMIT = (3 * NOMINAL) / 2;
  localparam int CNT_W      = $clog2(LOST_LIMIT + 1);

  logic              cal_en, fine_sel, ready_flag, lost_flag;
  logic [STEP_W-1:0] step;
  logic              sof_event, meas_valid, lost_event, lock_event;
  logic [CNT_W:0]    period;

  ot_sof_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .enable(cal_en),
    .sof_async(sof_in), .sof_event(sof_event)
  );

  ot_period_meter #(.NOMINAL(NOMINAL), .LOST_LIMIT(LOST_LIMIT), .CNT_W(CNT_W)) u_meter (
    .clk(clk), .rst_n(rst_n), .cal_en(cal_en), .sof_event(sof_event),
    .lost_flag(lost_flag), .meas_valid(meas_valid), .period(period),
    .lost_event(lost_event)
  );

  ot_trim_servo #(
    .NOMINAL(NOMINAL), .COARSE_W(COARSE_W), .FINE_W(FINE_W),
    .COARSE_INIT(COARSE_INIT), .FINE_INIT(FINE_INIT),
    .STEP_W(STEP_W), .PER_W(CNT_W + 1)
  ) u_servo (
    .clk(clk), .rst_n(rst_n), .cal_en(cal_en), .fine_sel(fine_sel),
    .step(step), .hold(ready_flag), .lost_flag(lost_flag),
    .meas_valid(meas_valid), .period(period),
    .coarse_word(coarse_trim), .fine_word(fine_trim), .lock_event(lock_event)
  );

  ot_ctrl_regs #(.STEP_W(STEP_W), .STEP_INIT(1)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lock_event(lock_event), .lost_event(lost_event),
    .cal_en(cal_en), .fine_sel(fine_sel), .step(step),
    .ready_flag(ready_flag), .lost_flag(lost_flag), .irq(irq)
  );

  a_r8_lost_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    lost_event |-> cal_en);
  a_r7_lock_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_event && !(reg_wr && reg_addr && !reg_wdata[0])) |=> ready_flag);

endmodule

// File: tb/osc_trim_ctrl_tb.sv
module osc_trim_ctrl_tb;
  localparam int NOM  = 800;
  localparam int LOST = 1200;
  localparam int KC   = 4;
  localparam int KF   = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sof_in = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic [7:0] coarse_trim;
  logic [5:0] fine_trim;
  logic       irq;

  int checks = 0, errors = 0;
  int offs = 0;
  bit gen_on = 1'b0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  osc_trim_ctrl #(.NOMINAL(NOM)) u_dut (
    .clk(clk), .rst_n(rst_n), .sof_in(sof_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .coarse_trim(coarse_trim), .fine_trim(fine_trim), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  bit m_s1, m_s2, m_s3, m_en, m_fsel, m_rie, m_lie, m_ready, m_lost, m_armed, m_hp;
  int m_step, m_cnt, m_pdir, m_perr, m_pword, m_coarse, m_fine;

  function automatic int iabs(int v); return v < 0 ? -v : v; endfunction

  task automatic model_reset();
    m_s1 = 0; m_s2 = 0; m_s3 = 0; m_en = 0; m_fsel = 0; m_rie = 0; m_lie = 0;
    m_ready = 0; m_lost = 0; m_armed = 0; m_hp = 0; m_step = 1; m_cnt = 0;
    m_pdir = 0; m_perr = 0; m_pword = 0; m_coarse = 128; m_fine = 32;
  endtask

  task automatic model_step();
    bit pulse, lost_ev, lock_ev, meas, new_hp;
    int e, w, d, maxw;
    pulse = m_s2 && !m_s3 && m_en;
    lost_ev = 0; lock_ev = 0; new_hp = 0;
    if (m_en) begin
      meas = pulse && m_armed && !m_lost;
      lost_ev = !pulse && (m_cnt == LOST - 1);
      if (meas && !m_ready) begin
        e = m_cnt + 1 - NOM;
        w = m_fsel ? m_fine : m_coarse;
        maxw = m_fsel ? 63 : 255;
        d = (e > 0) ? 2 : ((e < 0) ? 1 : 0);
        if (d == 0) lock_ev = 1;
        else if (m_hp && d != m_pdir) begin
          lock_ev = 1;
          if (iabs(m_perr) < iabs(e)) w = m_pword;
        end else begin
          m_pword = w; m_perr = e; m_pdir = d; new_hp = 1;
          w = (d == 1) ? w + m_step : w - m_step;
          if (w < 0) w = 0;
          if (w > maxw) w = maxw;
        end
        if (m_fsel) m_fine = w; else m_coarse = w;
      end
    end
    if (!m_en || m_ready || m_lost) m_hp = 0; else if (new_hp) m_hp = 1;
    if (!m_en) begin m_cnt = 0; m_armed = 0; end
    else if (pulse) begin m_cnt = 0; m_armed = 1; end
    else begin
      if (m_cnt < LOST) m_cnt++;
      if (lost_ev) m_armed = 0;
    end
    if (!m_en) begin m_ready = 0; m_lost = 0; end
    else begin
      if (lock_ev) m_ready = 1;
      if (lost_ev) m_lost = 1;
      if (reg_wr && reg_addr && !reg_wdata[0]) m_ready = 0;
      if (reg_wr && reg_addr && !reg_wdata[1]) m_lost = 0;
    end
    if (reg_wr && !reg_addr) begin
      m_en = reg_wdata[0]; m_fsel = reg_wdata[1]; m_rie = reg_wdata[2];
      m_lie = reg_wdata[3]; m_step = int'(reg_wdata[7:4]);
    end
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = sof_in;
  endtask

  task automatic check_val(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int exp_rd, exp_irq;
    if (!rst_n) model_reset(); else model_step();
    #5;
    if (cmp_on && !done) begin
      exp_irq = (m_ready && m_rie) || (m_lost && m_lie);
      exp_rd = !reg_rd ? 0 : (!reg_addr ? (m_step * 16 + m_lie * 8 + m_rie * 4 + m_fsel * 2 + m_en)
                                        : (m_lost * 2 + m_ready));
      check_val("R4 R6 coarse trim per-cycle", int'(coarse_trim), m_coarse);
      check_val("R5 fine trim per-cycle", int'(fine_trim), m_fine);
      check_val("R10 irq per-cycle", int'(irq), exp_irq);
      check_val("R2 R9 read data per-cycle", int'(reg_rdata), exp_rd);
    end
  end

  // ---------------- oscillator / reference model ----------------
  initial begin
    forever begin
      @(negedge clk);
      if (gen_on) begin
        int n;
        sof_in = 1'b1;
        repeat (2) @(negedge clk);
        sof_in = 1'b0;
        repeat (3) @(negedge clk);
        n = NOM + offs + (int'(coarse_trim) - 128) * KC + (int'(fine_trim) - 32) * KF;
        repeat (n - 6) @(negedge clk);
      end
    end
  end

  task automatic write_reg(bit a, logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = 8'd0;
  endtask

  task automatic read_check(bit a, int exp, string tag);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); #5;
    check_val(tag, int'(reg_rdata), exp);
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_ready(int max_cycles);
    for (int i = 0; i < max_cycles && !m_ready; i++) @(posedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    check_val("R1 coarse after reset", int'(coarse_trim), 128);
    check_val("R1 fine after reset", int'(fine_trim), 32);
    check_val("R1 irq after reset", int'(irq), 0);
    read_check(1'b0, 8'h10, "R1 R2 control after reset");
    read_check(1'b1, 0, "R1 status after reset");
    // R2 layout
    write_reg(1'b0, 8'h3C);
    read_check(1'b0, 8'h3C, "R2 control readback");
    write_reg(1'b0, 8'h10);

    // R4 R7 coarse search, lock interrupt enabled
    offs = 22; gen_on = 1'b1;
    write_reg(1'b0, 8'h15);
    wait_ready(20000);
    read_check(1'b1, 1, "R7 lock flag after coarse search");
    check_val("R4 R7 coarse lock value", int'(coarse_trim), 122);
    check_val("R5 fine untouched in coarse mode", int'(fine_trim), 32);
    check_val("R10 irq on lock", int'(irq), 1);

    // R9 writing ones ignored, zero clears; R11 restart
    write_reg(1'b1, 8'h03);
    read_check(1'b1, 1, "R9 write one keeps lock");
    write_reg(1'b1, 8'h00);
    check_val("R9 irq after software clear", int'(irq), 0);
    read_check(1'b1, 0, "R9 lock cleared by zero write");
    wait_ready(20000);
    check_val("R11 coarse after fresh search", int'(coarse_trim), 123);

    // R9 disable clears flags
    write_reg(1'b0, 8'h14);
    read_check(1'b1, 0, "R9 flags cleared by disable");
    check_val("R9 irq after disable", int'(irq), 0);

    // R3 references ignored while disabled
    repeat (2000) @(negedge clk);
    check_val("R3 coarse unchanged while disabled", int'(coarse_trim), 123);

    // R5 fine search reaching zero error
    offs = 30;
    write_reg(1'b0, 8'h17);
    wait_ready(20000);
    check_val("R5 R7 fine lock at zero error", int'(fine_trim), 27);
    check_val("R5 coarse untouched in fine mode", int'(coarse_trim), 123);

    // R7 restore of the better previous word
    write_reg(1'b0, 8'h16);
    offs = 32;
    write_reg(1'b0, 8'h37);
    wait_ready(20000);
    check_val("R7 fine restored to better word", int'(fine_trim), 27);

    // R8 lost reference
    write_reg(1'b0, 8'h36);
    gen_on = 1'b0;
    repeat (1000) @(negedge clk);
    write_reg(1'b0, 8'h19);
    repeat (LOST + 50) @(negedge clk);
    read_check(1'b1, 2, "R8 lost flag set");
    check_val("R10 irq on lost", int'(irq), 1);
    offs = 22; gen_on = 1'b1;
    repeat (2500) @(negedge clk);
    check_val("R8 coarse frozen while lost", int'(coarse_trim), 123);
    write_reg(1'b1, 8'h01);
    read_check(1'b1, 0, "R9 lost cleared by zero write");
    write_reg(1'b0, 8'h00);

    // R6 saturation at the top
    offs = -700;
    write_reg(1'b0, 8'hF1);
    repeat (8000) @(negedge clk);
    check_val("R6 coarse saturates at maximum", int'(coarse_trim), 255);
    read_check(1'b1, 0, "R6 no lock while saturated");
    write_reg(1'b0, 8'h00);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule